// File: doc/BRIEF.md
# Descriptor Chain Fetch Sequencer

This block walks a linked chain of command nodes held in memory and hands each node to a transfer engine. Software first writes the byte address of the head node into the node-pointer register of the channel bank. It then writes the control register with the list-enable bit set. The sequencer reads the node's eight 32-bit words over a single-outstanding word-read port, presents them to the engine as one command, pulses a start strobe, and waits for the engine's done pulse. It then follows the node's link word to the next node.

A link word of zero ends the chain and the channel returns to idle. A link that points back at an earlier node forms a ring, and the ring runs until software cancels. The block emits three kinds of event. A load event marks that the chain has been taken up; it fires together with the first command start, before any data command has finished. A command-done event follows each engine completion. An abort strobe tells the engine to stop when the channel is cancelled.

Top module: `desc_chain_seq`

## Requirements
- R1: After reset, busy, memReq, cmdStart, loadEvt, cmdDoneEvt and engAbort are all 0.
- R2: A write to bank offset 0x1C with bit 4 set and bit 20 clear, while idle, starts a fetch from the address last written to offset 0x14. A write to 0x1C without bit 4, or a write to any other offset, does not start the channel.
- R3: Each node is read as eight word requests at addresses node+0, node+4, ..., node+28 in ascending order. A request holds its address until memAck.
- R4: The cycle after the eighth word is accepted, cmdStart is high for exactly one cycle. The outputs then carry word 0 (general config), word 1 (port config), word 2 (source), word 3 (destination), word 4 (size), word 5 (link), word 6 (done count) and word 7 (control/status). All eight outputs hold steady until the engine reports done.
- R5: loadEvt pulses exactly once per started chain, in the same cycle as the first cmdStart. It does not pulse for later nodes, including later laps of a ring.
- R6: No memory request is issued between a cmdStart and the matching engDone.
- R7: Each engDone received while a command runs gives exactly one cmdDoneEvt pulse, one cycle later. An engDone while idle has no effect.
- R8: After done, a link word of 0 returns the channel to idle (busy low). A nonzero link word starts fetching the node at that address.
- R9: A ring of nodes whose last link points to the first node repeats its commands in order without end.
- R10: A write to offset 0x1C with bit 20 set stops the channel in any state. In the following cycle busy and memReq are 0 and engAbort is high for one cycle. Cancel wins over a list-enable bit set in the same write.
- R11: The two low bits of the head address and of each link word are ignored, so every memory address is word aligned.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 6 | Byte offset within the channel bank |
| regWrData | input | 32 | Register write data |
| memReq | output | 1 | Word read request, held until memAck |
| memAddr | output | 32 | Byte address of the requested word |
| memAck | input | 1 | Read data valid; completes the request |
| memRdData | input | 32 | Read data |
| engGenCfg | output | 32 | Loaded node word 0 |
| engPortCfg | output | 32 | Loaded node word 1 |
| engSrcAddr | output | 32 | Loaded node word 2 |
| engDstAddr | output | 32 | Loaded node word 3 |
| engXferSize | output | 32 | Loaded node word 4 |
| engNextAddr | output | 32 | Loaded node word 5 (link) |
| engDoneCount | output | 32 | Loaded node word 6 |
| engCtrlStat | output | 32 | Loaded node word 7 |
| cmdStart | output | 1 | One-cycle start of the loaded command |
| engDone | input | 1 | Engine completion pulse |
| engAbort | output | 1 | One-cycle stop strobe to the engine |
| loadEvt | output | 1 | Chain-loaded event |
| cmdDoneEvt | output | 1 | Command-completed event |
| busy | output | 1 | Channel active |

## Verification
A wrong word index or node pointer shows up at once as a memory address out of sequence. A swapped or mislatched field reaches the engine outputs at the next cmdStart. A bad link decode shows up within one node as a command order that differs from the walk of the chain in memory. For a ring, it can also show as a channel that goes idle when it should keep running. A stuck first-node flag shows as a wrong count of load events by the end of the chain. A cancel that does not take effect shows in the very next cycle as busy or memReq still high.

// File: rtl/desc_chain_pkg.sv
package desc_chain_pkg;
  localparam int NODE_WORDS = 8;
  localparam int IDX_W      = $clog2(NODE_WORDS);
  localparam int FLD_GEN    = 0;
  localparam int FLD_PORT   = 1;
  localparam int FLD_SRC    = 2;
  localparam int FLD_DST    = 3;
  localparam int FLD_SIZE   = 4;
  localparam int FLD_NEXT   = 5;
  localparam int FLD_DONE   = 6;
  localparam int FLD_CTRL   = 7;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_FETCH  = 2'd1,
    ST_LAUNCH = 2'd2,
    ST_RUN    = 2'd3
  } seqState_t;

  typedef struct packed {
    logic             capture;
    logic [IDX_W-1:0] wordIdx;
    logic             ptrFromReg;
    logic             ptrFromNext;
  } dpStrobe_t;
endpackage

// File: rtl/desc_chain_dp.sv
module desc_chain_dp
  import desc_chain_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         nodeRegWr,
  input  logic [DATA_W-1:0]            nodeRegData,
  input  dpStrobe_t                    stb,
  input  logic [DATA_W-1:0]            memRdData,
  output logic [ADDR_W-1:0]            memAddr,
  output logic [NODE_WORDS*DATA_W-1:0] fieldsFlat,
  output logic                         nextZero
);
  localparam int PTR_W = ADDR_W - 2;

  logic [PTR_W-1:0]  nodeReg;
  logic [PTR_W-1:0]  curPtr;
  logic [DATA_W-1:0] fieldQ [NODE_WORDS];

  // node pointer register: low two bits dropped, so word aligned
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      nodeReg <= '0;
    end else if (nodeRegWr) begin
      nodeReg <= nodeRegData[ADDR_W-1:2];
    end
  end

  // current node pointer
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      curPtr <= '0;
    end else if (stb.ptrFromReg) begin
      curPtr <= nodeReg;
    end else if (stb.ptrFromNext) begin
      curPtr <= fieldQ[FLD_NEXT][ADDR_W-1:2];
    end
  end

  // one capture register per node word
  for (genvar g = 0; g < NODE_WORDS; g++) begin : gField
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        fieldQ[g] <= '0;
      end else if (stb.capture && (stb.wordIdx == IDX_W'(g))) begin
        fieldQ[g] <= memRdData;
      end
    end
    assign fieldsFlat[g*DATA_W +: DATA_W] = fieldQ[g];
  end

  assign memAddr  = {curPtr, 2'b00} + ADDR_W'({stb.wordIdx, 2'b00});
  assign nextZero = (fieldQ[FLD_NEXT][ADDR_W-1:2] == '0);
endmodule

// File: rtl/desc_chain_ctrl.sv
module desc_chain_ctrl
  import desc_chain_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      startReq,
  input  logic      cancelReq,
  input  logic      memAck,
  input  logic      engDone,
  input  logic      nextZero,
  output dpStrobe_t stb,
  output logic      memReq,
  output logic      cmdStart,
  output logic      loadEvt,
  output logic      cmdDoneEvt,
  output logic      engAbort,
  output logic      busy
);
  seqState_t        state, stateNxt;
  logic [IDX_W-1:0] wordIdx;
  logic             firstNode;
  logic             lastWord;
  logic             wordTaken;
  logic             doneTaken;

  assign memReq    = (state == ST_FETCH);
  assign wordTaken = memReq && memAck;
  assign lastWord  = (wordIdx == IDX_W'(NODE_WORDS - 1));
  assign doneTaken = (state == ST_RUN) && engDone && !cancelReq;
  assign cmdStart  = (state == ST_LAUNCH);
  assign loadEvt   = (state == ST_LAUNCH) && firstNode;
  assign busy      = (state != ST_IDLE);

  always_comb begin
    stateNxt = state;
    if (cancelReq) begin
      stateNxt = ST_IDLE;
    end else begin
      unique case (state)
        ST_IDLE:   if (startReq) stateNxt = ST_FETCH;
        ST_FETCH:  if (wordTaken && lastWord) stateNxt = ST_LAUNCH;
        ST_LAUNCH: stateNxt = ST_RUN;
        ST_RUN:    if (engDone) stateNxt = nextZero ? ST_IDLE : ST_FETCH;
        default:   stateNxt = ST_IDLE;
      endcase
    end
  end

  always_comb begin
    stb.capture     = wordTaken && !cancelReq;
    stb.wordIdx     = wordIdx;
    stb.ptrFromReg  = (state == ST_IDLE) && startReq && !cancelReq;
    stb.ptrFromNext = doneTaken && !nextZero;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state      <= ST_IDLE;
      wordIdx    <= '0;
      firstNode  <= 1'b0;
      cmdDoneEvt <= 1'b0;
      engAbort   <= 1'b0;
    end else begin
      state      <= stateNxt;
      cmdDoneEvt <= doneTaken;
      engAbort   <= cancelReq;
      if (cancelReq || stb.ptrFromReg) begin
        wordIdx <= '0;
      end else if (wordTaken) begin
        wordIdx <= lastWord ? '0 : wordIdx + 1'b1;
      end
      if (stb.ptrFromReg) begin
        firstNode <= 1'b1;
      end else if (cancelReq || state == ST_LAUNCH) begin
        firstNode <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/desc_chain_seq.sv
module desc_chain_seq
  import desc_chain_pkg::*;
#(
  parameter int          ADDR_W      = 32,
  parameter int          DATA_W      = 32,
  parameter int          OFS_W       = 6,
  parameter logic [5:0]  NODE_OFS    = 6'h14,
  parameter logic [5:0]  CTRL_OFS    = 6'h1C,
  parameter int          LIST_EN_BIT = 4,
  parameter int          CANCEL_BIT  = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              regWrEn,
  input  logic [OFS_W-1:0]  regAddr,
  input  logic [DATA_W-1:0] regWrData,
  output logic              memReq,
  output logic [ADDR_W-1:0] memAddr,
  input  logic              memAck,
  input  logic [DATA_W-1:0] memRdData,
  output logic [DATA_W-1:0] engGenCfg,
  output logic [DATA_W-1:0] engPortCfg,
  output logic [DATA_W-1:0] engSrcAddr,
  output logic [DATA_W-1:0] engDstAddr,
  output logic [DATA_W-1:0] engXferSize,
  output logic [DATA_W-1:0] engNextAddr,
  output logic [DATA_W-1:0] engDoneCount,
  output logic [DATA_W-1:0] engCtrlStat,
  output logic              cmdStart,
  input  logic              engDone,
  output logic              engAbort,
  output logic              loadEvt,
  output logic              cmdDoneEvt,
  output logic              busy
);
  logic                         ctrlWr;
  logic                         nodeRegWr;
  logic                         startReq;
  logic                         cancelReq;
  logic                         nextZero;
  dpStrobe_t                    stb;
  logic [NODE_WORDS*DATA_W-1:0] fieldsFlat;

  assign ctrlWr    = regWrEn && (regAddr == OFS_W'(CTRL_OFS));
  assign nodeRegWr = regWrEn && (regAddr == OFS_W'(NODE_OFS));
  assign cancelReq = ctrlWr && regWrData[CANCEL_BIT];
  assign startReq  = ctrlWr && regWrData[LIST_EN_BIT];

  desc_chain_ctrl u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .startReq   (startReq),
    .cancelReq  (cancelReq),
    .memAck     (memAck),
    .engDone    (engDone),
    .nextZero   (nextZero),
    .stb        (stb),
    .memReq     (memReq),
    .cmdStart   (cmdStart),
    .loadEvt    (loadEvt),
    .cmdDoneEvt (cmdDoneEvt),
    .engAbort   (engAbort),
    .busy       (busy)
  );

  desc_chain_dp #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dp (
    .clk         (clk),
    .rst_n       (rst_n),
    .nodeRegWr   (nodeRegWr),
    .nodeRegData (regWrData),
    .stb         (stb),
    .memRdData   (memRdData),
    .memAddr     (memAddr),
    .fieldsFlat  (fieldsFlat),
    .nextZero    (nextZero)
  );

  assign engGenCfg    = fieldsFlat[FLD_GEN*DATA_W  +: DATA_W];
  assign engPortCfg   = fieldsFlat[FLD_PORT*DATA_W +: DATA_W];
  assign engSrcAddr   = fieldsFlat[FLD_SRC*DATA_W  +: DATA_W];
  assign engDstAddr   = fieldsFlat[FLD_DST*DATA_W  +: DATA_W];
  assign engXferSize  = fieldsFlat[FLD_SIZE*DATA_W +: DATA_W];
  assign engNextAddr  = fieldsFlat[FLD_NEXT*DATA_W +: DATA_W];
  assign engDoneCount = fieldsFlat[FLD_DONE*DATA_W +: DATA_W];
  assign engCtrlStat  = fieldsFlat[FLD_CTRL*DATA_W +: DATA_W];
endmodule

// File: rtl/desc_chain_chk.sv
module desc_chain_chk #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int OFS_W  = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic              regWrEn,
  input logic [OFS_W-1:0]  regAddr,
  input logic [DATA_W-1:0] regWrData,
  input logic              memReq,
  input logic [ADDR_W-1:0] memAddr,
  input logic              memAck,
  input logic [DATA_W-1:0] engSrcAddr,
  input logic [DATA_W-1:0] engCtrlStat,
  input logic              cmdStart,
  input logic              engDone,
  input logic              engAbort,
  input logic              loadEvt,
  input logic              cmdDoneEvt,
  input logic              busy
);
  logic cancelWr;
  logic runFlag;

  assign cancelWr = regWrEn && (regAddr == OFS_W'(6'h1C)) && regWrData[20];

  always_ff @(posedge clk) begin
    if (!rst_n) runFlag <= 1'b0;
    else if (cancelWr || engDone) runFlag <= 1'b0;
    else if (cmdStart) runFlag <= 1'b1;
  end

  a_r11_word_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    memReq |-> (memAddr[1:0] == 2'b00));
  a_r3_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
    (memReq && memAck) |=> (!memReq || memAddr == $past(memAddr) + ADDR_W'(4)));
  a_r3_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (memReq && !memAck && !cancelWr) |=> (memReq && $stable(memAddr)));
  a_r4_start_single: assert property (@(posedge clk) disable iff (!rst_n)
    cmdStart |=> !cmdStart);
  a_r4_fields_steady: assert property (@(posedge clk) disable iff (!rst_n)
    (runFlag && !cmdStart) |-> ($stable(engSrcAddr) && $stable(engCtrlStat)));
  a_r5_load_with_start: assert property (@(posedge clk) disable iff (!rst_n)
    loadEvt |-> cmdStart);
  a_r6_no_fetch_running: assert property (@(posedge clk) disable iff (!rst_n)
    runFlag |-> !memReq);
  a_r7_done_follows: assert property (@(posedge clk) disable iff (!rst_n)
    cmdDoneEvt |-> $past(engDone));
  a_r10_cancel_stops: assert property (@(posedge clk) disable iff (!rst_n)
    cancelWr |=> (!busy && !memReq && engAbort));
endmodule

bind desc_chain_seq desc_chain_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .OFS_W(OFS_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .regWrEn     (regWrEn),
  .regAddr     (regAddr),
  .regWrData   (regWrData),
  .memReq      (memReq),
  .memAddr     (memAddr),
  .memAck      (memAck),
  .engSrcAddr  (engSrcAddr),
  .engCtrlStat (engCtrlStat),
  .cmdStart    (cmdStart),
  .engDone     (engDone),
  .engAbort    (engAbort),
  .loadEvt     (loadEvt),
  .cmdDoneEvt  (cmdDoneEvt),
  .busy        (busy)
);

// File: tb/desc_chain_seq_tb.sv
module desc_chain_seq_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        regWrEn = 1'b0;
  logic [5:0]  regAddr = '0;
  logic [31:0] regWrData = '0;
  logic        memReq;
  logic [31:0] memAddr;
  logic        memAck = 1'b0;
  logic [31:0] memRdData = '0;
  logic [31:0] engGenCfg, engPortCfg, engSrcAddr, engDstAddr;
  logic [31:0] engXferSize, engNextAddr, engDoneCount, engCtrlStat;
  logic        cmdStart, engAbort, loadEvt, cmdDoneEvt, busy;
  logic        engDone = 1'b0;

  desc_chain_seq u_dut (
    .clk(clk), .rst_n(rst_n), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .memReq(memReq), .memAddr(memAddr),
    .memAck(memAck), .memRdData(memRdData), .engGenCfg(engGenCfg),
    .engPortCfg(engPortCfg), .engSrcAddr(engSrcAddr), .engDstAddr(engDstAddr),
    .engXferSize(engXferSize), .engNextAddr(engNextAddr),
    .engDoneCount(engDoneCount), .engCtrlStat(engCtrlStat),
    .cmdStart(cmdStart), .engDone(engDone), .engAbort(engAbort),
    .loadEvt(loadEvt), .cmdDoneEvt(cmdDoneEvt), .busy(busy)
  );

  initial forever #4 clk = ~clk;

  logic [31:0] mem [256];
  int checks = 0, fails = 0;
  int fetchLog [64];
  int fetchN = 0;
  int tagLog [64];
  int tagN = 0;
  int loadN = 0, doneN = 0, abortN = 0, r6Err = 0, fieldErr = 0;
  bit forceDone = 1'b0;
  int expTag [64];
  int expAddr [64];
  int expN;

  function automatic logic [31:0] pat(input int tag, input int k);
    return 32'hC000_0000 | (32'(k) << 24) | (32'(tag & 8'hFF) << 8) | 32'(k);
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // memory responder: random latency 0..2 cycles
  initial begin
    int memWait = 0;
    forever begin
      @(negedge clk);
      if (memReq && memWait == 0) begin
        memAck    = 1'b1;
        memRdData = mem[memAddr[9:2]];
        if (fetchN < 64) fetchLog[fetchN] = memAddr;
        fetchN++;
        memWait = $urandom % 3;
      end else begin
        memAck = 1'b0;
        if (memReq && memWait > 0) memWait--;
      end
    end
  end

  // transfer engine model
  initial begin
    bit pend = 1'b0;
    int cnt = 0;
    forever begin
      @(negedge clk);
      engDone = forceDone;
      if (engAbort) begin pend = 1'b0; abortN++; end
      if (loadEvt) loadN++;
      if (cmdDoneEvt) doneN++;
      if (pend && memReq) r6Err++;
      if (pend) begin
        if (cnt <= 1) begin engDone = 1'b1; pend = 1'b0; end
        else cnt--;
      end
      if (cmdStart) begin
        int t;
        t = int'(engCtrlStat[15:8]);
        if (tagN < 64) tagLog[tagN] = t;
        tagN++;
        if (engGenCfg != pat(t,0) || engPortCfg != pat(t,1) || engSrcAddr != pat(t,2) ||
            engDstAddr != pat(t,3) || engXferSize != pat(t,4) ||
            engDoneCount != pat(t,6) || engCtrlStat != pat(t,7)) fieldErr++;
        pend = 1'b1;
        cnt  = 1 + ($urandom % 4);
      end
    end
  end

  task automatic regWrite(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk);
    regWrEn = 1'b1; regAddr = a; regWrData = d;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic putNode(input int addr, input int tag, input int nxt);
    for (int k = 0; k < 8; k++) mem[(addr >> 2) + k] = pat(tag, k);
    mem[(addr >> 2) + 5] = nxt;
  endtask

  // expected walk of the chain in memory, independent of the design
  task automatic walk(input int head, input int maxN);
    int p;
    p = head & ~3;
    expN = 0;
    while (p != 0 && expN < maxN) begin
      expTag[expN]  = int'(mem[(p >> 2) + 7][15:8]);
      expAddr[expN] = p;
      expN++;
      p = int'(mem[(p >> 2) + 5]) & ~3;
    end
  endtask

  task automatic clearLogs();
    fetchN = 0; tagN = 0; loadN = 0; doneN = 0; abortN = 0; r6Err = 0; fieldErr = 0;
  endtask

  task automatic runChain(input int head, input bit ring, input int stopAfter,
                          input string tagReq);
    int guard;
    clearLogs();
    regWrite(6'h14, head);
    regWrite(6'h1C, 32'h10);
    guard = 0;
    if (ring) begin
      while (tagN < stopAfter && guard < 4000) begin @(negedge clk); guard++; end
      regWrite(6'h1C, 32'h0010_0010);
      chk(!busy && !memReq, "R10", "ring cancel idle", busy, 0);
      chk(abortN == 1, "R10", "abort pulses", abortN, 1);
      walk(head, stopAfter);
    end else begin
      while (busy && guard < 4000) begin @(negedge clk); guard++; end
      @(negedge clk);
      walk(head, 64);
      chk(doneN == expN, "R7", "done events", doneN, expN);
      chk(fetchN == 8 * expN, "R3", "fetch count", fetchN, 8 * expN);
      chk(!busy, "R8", "idle after last link", busy, 0);
    end
    chk(guard < 4000, tagReq, "no hang", guard, 0);
    chk(tagN == expN, tagReq, "command count", tagN, expN);
    for (int i = 0; i < expN && i < tagN; i++)
      chk(tagLog[i] == expTag[i], tagReq, "command order", tagLog[i], expTag[i]);
    for (int i = 0; i < 8 * expN && i < fetchN && i < 64; i++)
      chk(fetchLog[i] == expAddr[i / 8] + 4 * (i % 8), "R3", "fetch address",
          fetchLog[i], expAddr[i / 8] + 4 * (i % 8));
    chk(loadN == 1, "R5", "one load event", loadN, 1);
    chk(fieldErr == 0, "R4", "loaded fields", fieldErr, 0);
    chk(r6Err == 0, "R6", "no fetch while running", r6Err, 0);
  endtask

  initial begin
    repeat (40000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    for (int i = 0; i < 256; i++) mem[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(!busy, "R1", "busy", busy, 0);
    chk(!memReq, "R1", "memReq", memReq, 0);
    chk(!cmdStart && !loadEvt && !cmdDoneEvt && !engAbort, "R1", "events", cmdStart, 0);

    // R2 non-starting writes
    putNode(32'h40, 1, 0);
    regWrite(6'h14, 32'h40);
    regWrite(6'h1C, 32'h1);
    chk(!busy && !memReq, "R2", "ctrl without list enable", busy, 0);
    regWrite(6'h18, 32'h10);
    chk(!busy && !memReq, "R2", "other offset", busy, 0);

    // R7 spurious done while idle
    clearLogs();
    @(negedge clk); forceDone = 1'b1;
    @(negedge clk); forceDone = 1'b0;
    repeat (2) @(negedge clk);
    chk(doneN == 0 && !busy, "R7", "idle done ignored", doneN, 0);

    // single node chain
    runChain(32'h40, 1'b0, 0, "R2");

    // three-node chain, unaligned head write (R11)
    putNode(32'h100, 7, 32'h60);
    putNode(32'h60, 8, 32'h1C3);
    putNode(32'h1C0, 9, 0);
    runChain(32'h103, 1'b0, 0, "R11");

    // ring of three nodes, seven commands then cancel
    putNode(32'h80, 20, 32'hE0);
    putNode(32'hE0, 21, 32'h120);
    putNode(32'h120, 22, 32'h80);
    runChain(32'h80, 1'b1, 7, "R9");

    // cancel in the middle of a fetch
    clearLogs();
    regWrite(6'h14, 32'h100);
    regWrite(6'h1C, 32'h10);
    repeat (3) @(negedge clk);
    regWrite(6'h1C, 32'h0010_0010);
    chk(!busy && !memReq, "R10", "cancel during fetch", busy, 0);
    repeat (6) @(negedge clk);
    chk(tagN == 0 && abortN == 1, "R10", "no start after cancel", tagN, 0);

    // random chains
    for (int r = 0; r < 8; r++) begin
      int len, s, slot, nslot;
      len = 1 + ($urandom % 4);
      s   = $urandom % 15;
      for (int i = 0; i < len; i++) begin
        slot  = 1 + ((s + i * 7) % 15);
        nslot = 1 + ((s + (i + 1) * 7) % 15);
        putNode(slot * 32'h40, 32 + r * 4 + i, (i == len - 1) ? 0 : nslot * 32'h40);
      end
      runChain((1 + s) * 32'h40, 1'b0, 0, "R8");
    end

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule